// File: doc/BRIEF.md
# Frame Clock Rate-Change Monitor

This block watches an audio frame clock with a fast, free-running oscillator clock. It measures every frame period as a count of oscillator cycles and learns a reference period once the rate has settled. After that it watches for a sustained change of rate and for a frame clock that has stopped. On either event it issues a one-cycle internal reset, drops the learned reference and starts learning again.

While no reference is held, and for a set number of frames after one has been learned, the block mutes the serial data path. A muted path drives zero, so downstream logic sees silence rather than distorted samples during a restart. The rate-conversion datapath sits outside the block. Only its output word passes through the gate here.

Top module: `frame_rate_guard`

## Requirements
- R1: With `rst` high at a clock edge, the block returns to the idle state. From the next cycle `locked` is 0, `mute` is 1, `int_reset` is 0 and `data_out` is 0.
- R2: The frame clock is brought in through a two-flop synchronizer, and only its rising edges count. The first edge after a (re)start only opens the measurement. A reference is captured once 4 consecutive periods all lie within ±100 cycles of the first of them. `locked` then goes to 1.
- R3: After `locked` rises, `mute` stays 1 for 6 more frame periods and then falls to 0. While `mute` is 1, `data_out` is 0. While `mute` is 0, `data_out` equals `data_in`.
- R4: A period that differs from the reference by 100 cycles or less is not a deviation. A run of such periods (for example 500 or 480 cycles against 400) causes no reset.
- R5: Fewer than 8 consecutive deviating periods never cause a reset. Any period within the threshold clears the run.
- R6: The 8th consecutive period that differs from the reference by more than 100 cycles produces exactly one `int_reset` pulse, one cycle wide.
- R7: An internal reset clears `locked` and sets `mute` on the next cycle. It discards the reference, and the block then learns the new rate.
- R8: While locked, a frame gap of up to 2×reference+1 cycles is still measured as a period. If the gap reaches 2×reference+2 cycles (capped at 1500 while not locked), the clock counts as stopped and `int_reset` pulses. Once stopped, no further reset occurs until a frame edge has been seen again.
- R9: `rst` clears the lock and mutes the output without producing an `int_reset` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast oscillator clock |
| rst | input | 1 | Synchronous active-high external reset |
| frame_clk | input | 1 | Asynchronous frame clock |
| data_in | input | DATA_W | Converted sample word to be gated |
| data_out | output | DATA_W | Gated sample word, zero while muted |
| int_reset | output | 1 | One-cycle internal reset request |
| mute | output | 1 | High while the data path is held silent |
| locked | output | 1 | High while a reference period is held |

## Verification
In one cycle the frame edge detector and the stop timeout can both claim the same counter state. A gap of exactly twice the reference plus one puts the incoming edge on the very cycle the counter reaches the timeout limit. The bench drives one frame of 801 cycles against a 400-cycle reference and expects the edge to win: no reset, lock kept. One cycle longer, an 802-cycle frame, must produce a single reset followed by a muted, unlocked output.

// File: rtl/frg_pkg.sv
package frg_pkg;

    parameter int unsigned CNT_W = 16;

    typedef enum logic [0:0] {
        ST_ACQUIRE = 1'b0,
        ST_TRACK   = 1'b1
    } trk_state_e;

    typedef struct packed {
        logic             valid;
        logic [CNT_W-1:0] cycles;
    } period_t;

    function automatic logic beyond(input logic [CNT_W-1:0] a,
                                    input logic [CNT_W-1:0] b,
                                    input logic [CNT_W-1:0] thr);
        logic [CNT_W-1:0] d;
        d = (a > b) ? (a - b) : (b - a);
        return d > thr;
    endfunction

endpackage

// File: rtl/frg_edge_sync.sv
module frg_edge_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_i,
    output logic rise_o
);
    logic [STAGES:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-1:0], async_i};
    end

    assign rise_o = chain[STAGES-1] & ~chain[STAGES];
endmodule

// File: rtl/frg_period_meter.sv
module frg_period_meter
    import frg_pkg::*;
#(
    parameter int unsigned TIMEOUT_MAX = 1500
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic             edge_i,
    input  logic             locked_i,
    input  logic [CNT_W-1:0] ref_i,
    output period_t          meas_o,
    output logic             stop_o
);
    logic [CNT_W-1:0] cnt;
    logic             armed;
    logic [CNT_W:0]   dbl;
    logic [CNT_W-1:0] limit;

    assign dbl = {ref_i, 1'b0};

    always_comb begin
        limit = CNT_W'(TIMEOUT_MAX);
        if (locked_i && (dbl < {1'b0, limit}))
            limit = dbl[CNT_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            cnt    <= '0;
            armed  <= 1'b0;
            meas_o <= '0;
            stop_o <= 1'b0;
        end else begin
            meas_o.valid <= 1'b0;
            stop_o       <= 1'b0;
            if (edge_i) begin
                if (armed) begin
                    meas_o.valid  <= 1'b1;
                    meas_o.cycles <= cnt + 1'b1;
                end
                armed <= 1'b1;
                cnt   <= '0;
            end else if (armed) begin
                if (cnt >= limit) begin
                    stop_o <= 1'b1;
                    armed  <= 1'b0;
                    cnt    <= '0;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/frg_lock_tracker.sv
module frg_lock_tracker
    import frg_pkg::*;
#(
    parameter int unsigned THRESH      = 100,
    parameter int unsigned LOCK_FRAMES = 4,
    parameter int unsigned RUN_LEN     = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  period_t          meas_i,
    input  logic             stop_i,
    output logic             locked_o,
    output logic [CNT_W-1:0] ref_o,
    output logic             int_rst_o
);
    localparam int unsigned AGW  = $clog2(LOCK_FRAMES + 1);
    localparam int unsigned RUNW = $clog2(RUN_LEN + 1);
    localparam logic [CNT_W-1:0] THR = CNT_W'(THRESH);

    trk_state_e       st;
    logic [CNT_W-1:0] cand;
    logic [CNT_W-1:0] refc;
    logic [AGW-1:0]   agree;
    logic [RUNW-1:0]  run;
    logic             off_ref;
    logic             dev_fire;

    assign off_ref  = beyond(meas_i.cycles, refc, THR);
    assign dev_fire = (st == ST_TRACK) && meas_i.valid && off_ref &&
                      (run == RUNW'(RUN_LEN - 1));

    always_ff @(posedge clk) begin
        if (rst) int_rst_o <= 1'b0;
        else     int_rst_o <= !int_rst_o && (dev_fire || stop_i);
    end

    always_ff @(posedge clk) begin
        if (rst || int_rst_o) begin
            st    <= ST_ACQUIRE;
            cand  <= '0;
            refc  <= '0;
            agree <= '0;
            run   <= '0;
        end else if (meas_i.valid) begin
            case (st)
                ST_ACQUIRE: begin
                    if (agree == '0 || beyond(meas_i.cycles, cand, THR)) begin
                        cand  <= meas_i.cycles;
                        agree <= AGW'(1);
                    end else if (agree == AGW'(LOCK_FRAMES - 1)) begin
                        refc <= cand;
                        st   <= ST_TRACK;
                        run  <= '0;
                    end else begin
                        agree <= agree + 1'b1;
                    end
                end
                ST_TRACK: begin
                    if (off_ref) run <= run + 1'b1;
                    else         run <= '0;
                end
                default: st <= ST_ACQUIRE;
            endcase
        end
    end

    assign locked_o = (st == ST_TRACK);
    assign ref_o    = refc;
endmodule

// File: rtl/frg_mute_hold.sv
module frg_mute_hold #(
    parameter int unsigned HOLD_FRAMES = 6
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    input  logic locked_i,
    input  logic frame_tick_i,
    output logic mute_o
);
    localparam int unsigned HW = $clog2(HOLD_FRAMES + 1);

    logic [HW-1:0] hcnt;
    logic          released;

    always_ff @(posedge clk) begin
        if (rst || restart || !locked_i) begin
            hcnt     <= '0;
            released <= 1'b0;
        end else if (!released && frame_tick_i) begin
            if (hcnt == HW'(HOLD_FRAMES - 1)) released <= 1'b1;
            else                              hcnt     <= hcnt + 1'b1;
        end
    end

    assign mute_o = !released;
endmodule

// File: rtl/frame_rate_guard.sv
module frame_rate_guard
    import frg_pkg::*;
#(
    parameter int unsigned DATA_W      = 16,
    parameter int unsigned THRESH      = 100,
    parameter int unsigned LOCK_FRAMES = 4,
    parameter int unsigned RUN_LEN     = 8,
    parameter int unsigned HOLD_FRAMES = 6,
    parameter int unsigned TIMEOUT_MAX = 1500,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_clk,
    input  logic [DATA_W-1:0] data_in,
    output logic [DATA_W-1:0] data_out,
    output logic              int_reset,
    output logic              mute,
    output logic              locked
);
    logic             rise;
    period_t          meas;
    logic             stop;
    logic [CNT_W-1:0] ref_cycles;
    logic             held_mute;

    frg_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .async_i(frame_clk), .rise_o(rise)
    );

    frg_period_meter #(.TIMEOUT_MAX(TIMEOUT_MAX)) u_meter (
        .clk(clk), .rst(rst), .restart(int_reset), .edge_i(rise),
        .locked_i(locked), .ref_i(ref_cycles), .meas_o(meas), .stop_o(stop)
    );

    frg_lock_tracker #(
        .THRESH(THRESH), .LOCK_FRAMES(LOCK_FRAMES), .RUN_LEN(RUN_LEN)
    ) u_track (
        .clk(clk), .rst(rst), .meas_i(meas), .stop_i(stop),
        .locked_o(locked), .ref_o(ref_cycles), .int_rst_o(int_reset)
    );

    frg_mute_hold #(.HOLD_FRAMES(HOLD_FRAMES)) u_hold (
        .clk(clk), .rst(rst), .restart(int_reset), .locked_i(locked),
        .frame_tick_i(meas.valid), .mute_o(held_mute)
    );

    assign mute     = held_mute | int_reset;
    assign data_out = mute ? '0 : data_in;
endmodule

// File: rtl/frg_checker.sv
module frg_checker #(
    parameter int unsigned DATA_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic [DATA_W-1:0] data_out,
    input logic              int_reset,
    input logic              mute,
    input logic              locked
);
    a_r6_single_pulse: assert property (@(posedge clk) disable iff (rst)
        int_reset |=> !int_reset);

    a_r7_clear_after_int: assert property (@(posedge clk) disable iff (rst)
        int_reset |=> (!locked && mute && data_out == '0));

    a_r2_muted_at_lock: assert property (@(posedge clk) disable iff (rst)
        $rose(locked) |-> mute);

    a_r3_release_needs_lock: assert property (@(posedge clk) disable iff (rst)
        $fell(mute) |-> locked);

    a_r9_ext_reset_clears: assert property (@(posedge clk)
        rst |=> (!locked && mute && !int_reset));
endmodule

bind frame_rate_guard frg_checker #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst(rst), .data_out(data_out), .int_reset(int_reset),
    .mute(mute), .locked(locked)
);

// File: tb/tb_frame_rate_guard.sv
`timescale 1ns/1ps
module tb_frame_rate_guard;
    localparam int DW = 16;
    localparam logic [DW-1:0] WORD = 16'hA5C3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          frame_clk = 1'b0;
    logic [DW-1:0] data_in = WORD;
    logic [DW-1:0] data_out;
    logic          int_reset, mute, locked;

    int n_tests = 0;
    int n_fail  = 0;
    int n_rst_seen = 0;
    int exp_rst = 0;

    typedef struct {
        string req;
        bit    lk;
        bit    mt;
        int    nr;
    } exp_t;
    exp_t q[$];

    always #4 clk = ~clk;

    frame_rate_guard dut (
        .clk(clk), .rst(rst), .frame_clk(frame_clk), .data_in(data_in),
        .data_out(data_out), .int_reset(int_reset), .mute(mute), .locked(locked)
    );

    always @(negedge clk) if (!rst && int_reset) n_rst_seen++;

    task automatic cmp(input string req, input string what, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // monitor: pops expectations and compares at negedge
    initial begin
        exp_t it;
        forever begin
            @(negedge clk);
            if (q.size() > 0) begin
                it = q.pop_front();
                cmp(it.req, "locked",   int'(locked), int'(it.lk));
                cmp(it.req, "mute",     int'(mute),   int'(it.mt));
                cmp(it.req, "data_out", int'(data_out), it.mt ? 0 : int'(WORD));
                cmp(it.req, "resets",   n_rst_seen,   it.nr);
            end
        end
    end

    task automatic expect_now(input string req, input bit lk, input bit mt);
        exp_t e;
        e.req = req; e.lk = lk; e.mt = mt; e.nr = exp_rst;
        q.push_back(e);
        while (q.size() != 0) @(negedge clk);
    endtask

    task automatic frame(input int p);
        frame_clk = 1'b1;
        repeat (p / 2) @(negedge clk);
        frame_clk = 1'b0;
        repeat (p - p / 2) @(negedge clk);
    endtask

    task automatic frames(input int n, input int p);
        for (int i = 0; i < n; i++) frame(p);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        expect_now("R1 reset state", 0, 1);

        frames(3, 400);
        expect_now("R2 not yet locked", 0, 1);
        frames(5, 400);
        expect_now("R2 locked, R3 still held", 1, 1);
        frames(4, 400);
        expect_now("R3 released", 1, 0);

        frames(10, 480); frames(2, 400);
        expect_now("R4 80 cycles off", 1, 0);
        frames(10, 500); frames(2, 400);
        expect_now("R4 exactly 100 off", 1, 0);

        frames(7, 600); frames(3, 400);
        expect_now("R5 seven long frames", 1, 0);
        frames(7, 299); frames(3, 400);
        expect_now("R5 seven short frames", 1, 0);
        frames(6, 600); frame(400); frames(6, 600); frames(3, 400);
        expect_now("R5 run cleared", 1, 0);

        frame(801); frames(3, 400);
        expect_now("R8 gap 2ref+1 measured", 1, 0);
        frame(802); frames(2, 400);
        exp_rst = 1;
        expect_now("R8 gap 2ref+2 stop, R7 cleared", 0, 1);
        frames(12, 400);
        expect_now("R7 relock after stop", 1, 0);

        frames(10, 520);
        exp_rst = 2;
        expect_now("R6 sustained deviation, R7 cleared", 0, 1);
        frames(12, 520);
        expect_now("R7 locked at new rate", 1, 0);

        repeat (1100) @(negedge clk);
        exp_rst = 3;
        expect_now("R8 stopped clock", 0, 1);
        repeat (3000) @(negedge clk);
        expect_now("R8 no repeat while stopped", 0, 1);
        frames(12, 400);
        expect_now("R8 restart relock", 1, 0);

        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        expect_now("R9 external reset", 0, 1);
        frames(12, 400);
        expect_now("R9 relock after external reset", 1, 0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule